// File: doc/BRIEF.md
# Single-Bank SDRAM Command Legality Monitor

This block follows one bank of a double-data-rate SDRAM through its command life cycle and says, for every clock, whether the command on the registered command pins is allowed in that bank's present state. It decodes chip select, row strobe, column strobe and write enable into one of nine commands. It also takes an auto-precharge flag and a precharge-all flag, a flag saying whether the command addresses this bank, and two summaries from the rest of the device: whether every other bank is idle, and whether another bank issued the newest read burst that is still running.

Timed states (row opening, precharge, reads and writes with auto-precharge, refresh, mode-register access, precharge of all banks, and the plain read and write bursts) are governed by one down-counter. It is loaded with a programmable cycle count when the starting command registers, and the state moves on when the count runs out. A window value of zero is treated as one cycle. An illegal command never changes the state. A monitor or a memory controller's self-check places one instance per bank and watches the legal flag.

Top module: `bkchk_top`

## Requirements
- R1: One clock after a command is sampled, `cmd_o` holds its code: Deselect 0 (chip select high), NOP 1 (RAS,CAS,WE = H,H,H), Active 2 (L,H,H), Read 3 (H,L,H), Write 4 (H,L,L), Burst Terminate 5 (H,H,L), Precharge 6 (L,H,L), Auto Refresh 7 (L,L,H), Mode Register Set 8 (L,L,L). `legal_o` reports on the same command in the same cycle. After reset `state_o`=Idle(0), `legal_o`=1 and `cmd_o`=0.
- R2: Deselect and NOP are legal in every state and change nothing except through an expiring timer.
- R3: In Idle (code 0), Active to this bank is legal and enters Opening (1). Auto Refresh and Mode Register Set are legal only while `peers_idle`=1. Read, Write and single-bank Precharge to this bank are illegal.
- R4: In Row Open (2), Read enters Reading (3), or Read-AutoPre (6) when `ap_flag`=1. Write enters Writing (4), or Write-AutoPre (7). Single-bank Precharge enters Precharging (5). Active is illegal.
- R5: In Reading (3), Read, Write and Precharge to this bank are legal and take the same targets as in Row Open. Active is illegal.
- R6: In Writing (4), Read, Write and Precharge are legal as in Reading. Active is illegal, and Burst Terminate is illegal unless another bank's read is newest.
- R7: Opening lasts `cfg_trcd` cycles and ends in Row Open. Precharging lasts `cfg_trp` cycles and ends in Idle. Read-AutoPre and Write-AutoPre last `cfg_burst`+`cfg_trp` cycles and end in Idle. In these four states, Active, Read, Write and Precharge to this bank, precharge-all, refresh and mode set are all illegal.
- R8: Refreshing (8, `cfg_trfc` cycles), Mode Access (9, `cfg_tmrd` cycles) and Precharging All (10, `cfg_trp` cycles) end in Idle. In them every command other than Deselect and NOP is illegal, whichever bank it names.
- R9: Burst Terminate ignores `bank_hit`. It is legal with no effect here when `peer_rd_recent`=1. Otherwise it is legal only in Reading, and it returns the bank to Row Open.
- R10: Precharge with `pall_flag`=1 ignores `bank_hit`. It is legal from Idle, Row Open, Reading and Writing, and enters Precharging All. From any other state it is illegal.
- R11: Active, Read, Write and single-bank Precharge with `bank_hit`=0 are legal and leave this bank's state alone, except in the device-wide states of R8.
- R12: An illegal command leaves the state unchanged.
- R13: Reading and Writing return to Row Open after `cfg_burst` cycles with no new Read or Write. A new Read or Write restarts the count. Any window set to 0 lasts one cycle. A timed state entered on the edge that samples its command holds for exactly its window of cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| ap_flag | input | 1 | Auto-precharge requested with Read/Write |
| pall_flag | input | 1 | Precharge applies to all banks |
| bank_hit | input | 1 | Command's bank address selects this bank |
| peers_idle | input | 1 | Every other bank is idle |
| peer_rd_recent | input | 1 | Another bank owns the newest running read burst |
| cfg_trp | input | TW | Precharge window in cycles |
| cfg_trcd | input | TW | Row-open window in cycles |
| cfg_trfc | input | TW | Refresh window in cycles |
| cfg_tmrd | input | TW | Mode-register window in cycles |
| cfg_burst | input | TW | Burst duration in cycles |
| state_o | output | 4 | Current bank state code |
| legal_o | output | 1 | Previous sampled command was legal |
| cmd_o | output | 4 | Code of previous sampled command |

## Verification
`legal_o` and `cmd_o` belong to the command sampled on the preceding rising edge. `state_o` takes its new value on that same edge, so all three are due one cycle after the stimulus. The bench drives each command on a falling edge and compares all three on the next falling edge. After a timed state is entered, the state code stays put for N-1 further cycles and then changes. The bench counts these cycles with NOPs or with the probing commands it inserts, and subtracts the probes from the window so that the exit is checked on exactly the Nth sample.

// File: rtl/bkchk_pkg.sv
package bkchk_pkg;

  typedef enum logic [3:0] {
    C_DESEL = 4'd0,
    C_NOP   = 4'd1,
    C_ACT   = 4'd2,
    C_RD    = 4'd3,
    C_WR    = 4'd4,
    C_BST   = 4'd5,
    C_PRE   = 4'd6,
    C_REF   = 4'd7,
    C_MRS   = 4'd8
  } cmd_e;

  typedef enum logic [3:0] {
    S_IDLE = 4'd0,
    S_OPEN = 4'd1,
    S_ROW  = 4'd2,
    S_RD   = 4'd3,
    S_WR   = 4'd4,
    S_PRE  = 4'd5,
    S_RDAP = 4'd6,
    S_WRAP = 4'd7,
    S_REF  = 4'd8,
    S_MODE = 4'd9,
    S_PALL = 4'd10
  } st_e;

  // Pin pattern to command.
  function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) c = C_DESEL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  c = C_NOP;
        3'b011:  c = C_ACT;
        3'b101:  c = C_RD;
        3'b100:  c = C_WR;
        3'b110:  c = C_BST;
        3'b010:  c = C_PRE;
        3'b001:  c = C_REF;
        default: c = C_MRS;
      endcase
    end
    return c;
  endfunction

  function automatic logic is_exec(input cmd_e c);
    return !(c == C_DESEL || c == C_NOP);
  endfunction

  // States that freeze the whole device.
  function automatic logic devwide(input st_e s);
    return (s == S_REF) || (s == S_MODE) || (s == S_PALL);
  endfunction

  // Bank-local states that must run to completion.
  function automatic logic bank_busy(input st_e s);
    return (s == S_OPEN) || (s == S_PRE) || (s == S_RDAP) || (s == S_WRAP);
  endfunction

  // States from which a precharge may be issued.
  function automatic logic pre_ok(input st_e s);
    return (s == S_IDLE) || (s == S_ROW) || (s == S_RD) || (s == S_WR);
  endfunction

  // Where a timed state goes when its window runs out.
  function automatic st_e settle(input st_e s);
    st_e r;
    case (s)
      S_OPEN, S_RD, S_WR:                     r = S_ROW;
      S_PRE, S_RDAP, S_WRAP, S_REF, S_MODE, S_PALL: r = S_IDLE;
      default:                                r = s;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bkchk_decode.sv
module bkchk_decode
  import bkchk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  assign cmd = decode_pins(cs_n, ras_n, cas_n, we_n);
endmodule

// File: rtl/bkchk_timer.sv
module bkchk_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  // Last cycle of the window: the count is about to reach zero.
  assign expire = (cnt == {{(CW-1){1'b0}}, 1'b1});
endmodule

// File: rtl/bkchk_rules.sv
module bkchk_rules
  import bkchk_pkg::*;
(
  input  st_e  st,
  input  cmd_e cmd,
  input  logic ap,
  input  logic pall,
  input  logic hit,
  input  logic peers_idle,
  input  logic peer_rd_recent,
  output logic legal,
  output logic go,
  output st_e  nxt
);
  always_comb begin
    legal = 1'b1;
    go    = 1'b0;
    nxt   = st;
    if (!is_exec(cmd)) begin
      legal = 1'b1;
    end else if (devwide(st)) begin
      legal = 1'b0;
    end else begin
      case (cmd)
        C_BST: begin
          if (peer_rd_recent) legal = 1'b1;
          else if (st == S_RD) begin
            go  = 1'b1;
            nxt = S_ROW;
          end else legal = 1'b0;
        end
        C_REF, C_MRS: begin
          if (st == S_IDLE && peers_idle) begin
            go  = 1'b1;
            nxt = (cmd == C_REF) ? S_REF : S_MODE;
          end else legal = 1'b0;
        end
        default: begin
          if (cmd == C_PRE && pall) begin
            if (pre_ok(st)) begin
              go  = 1'b1;
              nxt = S_PALL;
            end else legal = 1'b0;
          end else if (!hit) begin
            legal = 1'b1;
          end else begin
            case (st)
              S_IDLE: begin
                if (cmd == C_ACT) begin
                  go  = 1'b1;
                  nxt = S_OPEN;
                end else legal = 1'b0;
              end
              S_ROW, S_RD, S_WR: begin
                case (cmd)
                  C_RD: begin
                    go  = 1'b1;
                    nxt = ap ? S_RDAP : S_RD;
                  end
                  C_WR: begin
                    go  = 1'b1;
                    nxt = ap ? S_WRAP : S_WR;
                  end
                  C_PRE: begin
                    go  = 1'b1;
                    nxt = S_PRE;
                  end
                  default: legal = 1'b0;
                endcase
              end
              default: legal = 1'b0;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/bkchk_top.sv
module bkchk_top
  import bkchk_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          ap_flag,
  input  logic          pall_flag,
  input  logic          bank_hit,
  input  logic          peers_idle,
  input  logic          peer_rd_recent,
  input  logic [TW-1:0] cfg_trp,
  input  logic [TW-1:0] cfg_trcd,
  input  logic [TW-1:0] cfg_trfc,
  input  logic [TW-1:0] cfg_tmrd,
  input  logic [TW-1:0] cfg_burst,
  output logic [3:0]    state_o,
  output logic          legal_o,
  output logic [3:0]    cmd_o
);
  localparam int CW = TW + 1;

  // Window length with zero mapped to one cycle.
  function automatic logic [CW-1:0] win(input logic [TW-1:0] n);
    return (n == '0) ? {{(CW-1){1'b0}}, 1'b1} : {1'b0, n};
  endfunction

  st_e           state;
  cmd_e          cmd_now;
  logic          legal_now;
  logic          go;
  st_e           nxt;
  logic          tmr_expire;
  logic [CW-1:0] ld_val;

  bkchk_decode u_dec (
    .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .cmd (cmd_now)
  );

  bkchk_rules u_rules (
    .st             (state),
    .cmd            (cmd_now),
    .ap             (ap_flag),
    .pall           (pall_flag),
    .hit            (bank_hit),
    .peers_idle     (peers_idle),
    .peer_rd_recent (peer_rd_recent),
    .legal          (legal_now),
    .go             (go),
    .nxt            (nxt)
  );

  always_comb begin
    case (nxt)
      S_OPEN:         ld_val = win(cfg_trcd);
      S_PRE, S_PALL:  ld_val = win(cfg_trp);
      S_RD, S_WR:     ld_val = win(cfg_burst);
      S_RDAP, S_WRAP: ld_val = win(cfg_burst) + win(cfg_trp);
      S_REF:          ld_val = win(cfg_trfc);
      S_MODE:         ld_val = win(cfg_tmrd);
      default:        ld_val = '0;
    endcase
  end

  bkchk_timer #(.CW(CW)) u_tmr (
    .clk (clk), .rst_n (rst_n), .load (go), .load_val (ld_val), .expire (tmr_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      legal_o <= 1'b1;
      cmd_o   <= C_DESEL;
    end else begin
      if (go)              state <= nxt;
      else if (tmr_expire) state <= settle(state);
      legal_o <= legal_now;
      cmd_o   <= cmd_now;
    end
  end

  assign state_o = state;
endmodule

// File: rtl/bkchk_sva.sv
module bkchk_sva
  import bkchk_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] state_o,
  input logic       legal_o,
  input cmd_e       cmd_now,
  input logic       bank_hit,
  input logic       peers_idle,
  input logic       go,
  input logic       tmr_expire
);
  st_e st;
  assign st = st_e'(state_o);

  p_quiet_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_now == C_DESEL || cmd_now == C_NOP) |=> legal_o);

  p_devwide_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (devwide(st) && is_exec(cmd_now)) |=> !legal_o);

  p_row_no_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ROW && cmd_now == C_ACT && bank_hit) |=> (!legal_o && state_o == 4'd2));

  p_idle_ref_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && (cmd_now == C_REF || cmd_now == C_MRS) && !peers_idle)
      |=> (!legal_o && state_o == 4'd0));

  p_busy_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_busy(st) && bank_hit && (cmd_now == C_ACT || cmd_now == C_RD || cmd_now == C_WR))
      |=> !legal_o);

  p_hold_state_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !tmr_expire) |=> $stable(state_o));
endmodule

bind bkchk_top bkchk_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .state_o    (state_o),
  .legal_o    (legal_o),
  .cmd_now    (cmd_now),
  .bank_hit   (bank_hit),
  .peers_idle (peers_idle),
  .go         (go),
  .tmr_expire (tmr_expire)
);

// File: tb/bkchk_top_test.sv
module bkchk_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;

  localparam logic [3:0] K_DES = 0, K_NOP = 1, K_ACT = 2, K_RD = 3, K_WR = 4,
                         K_BST = 5, K_PRE = 6, K_REF = 7, K_MRS = 8;
  localparam logic [3:0] Q_IDLE = 0, Q_OPEN = 1, Q_ROW = 2, Q_RD = 3, Q_WR = 4,
                         Q_PRE = 5, Q_RDAP = 6, Q_WRAP = 7, Q_REF = 8,
                         Q_MODE = 9, Q_PALL = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic ap_flag = 1'b0, pall_flag = 1'b0, bank_hit = 1'b0;
  logic peers_idle = 1'b1, peer_rd_recent = 1'b0;
  logic [TW-1:0] cfg_trp = 8'd2, cfg_trcd = 8'd3, cfg_trfc = 8'd5;
  logic [TW-1:0] cfg_tmrd = 8'd2, cfg_burst = 8'd4;
  logic [3:0] state_o, cmd_o;
  logic legal_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkchk_top #(.TW(TW)) uut (
    .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
    .we_n (we_n), .ap_flag (ap_flag), .pall_flag (pall_flag), .bank_hit (bank_hit),
    .peers_idle (peers_idle), .peer_rd_recent (peer_rd_recent), .cfg_trp (cfg_trp),
    .cfg_trcd (cfg_trcd), .cfg_trfc (cfg_trfc), .cfg_tmrd (cfg_tmrd),
    .cfg_burst (cfg_burst), .state_o (state_o), .legal_o (legal_o), .cmd_o (cmd_o)
  );

  task automatic compare(input logic [3:0] got, input logic [3:0] exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic pins(input logic [3:0] c);
    case (c)
      K_DES:   {cs_n, ras_n, cas_n, we_n} = 4'b1111;
      K_NOP:   {cs_n, ras_n, cas_n, we_n} = 4'b0111;
      K_ACT:   {cs_n, ras_n, cas_n, we_n} = 4'b0011;
      K_RD:    {cs_n, ras_n, cas_n, we_n} = 4'b0101;
      K_WR:    {cs_n, ras_n, cas_n, we_n} = 4'b0100;
      K_BST:   {cs_n, ras_n, cas_n, we_n} = 4'b0110;
      K_PRE:   {cs_n, ras_n, cas_n, we_n} = 4'b0010;
      K_REF:   {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
    endcase
  endtask

  // Called at a falling edge; checks the results one edge later.
  task automatic send(input logic [3:0] c, input logic ap, input logic pl, input logic ht,
                      input logic exp_l, input logic [3:0] exp_s, input string tag);
    pins(c);
    ap_flag = ap; pall_flag = pl; bank_hit = ht;
    @(negedge clk);
    compare({3'b0, legal_o}, {3'b0, exp_l}, {tag, " legal"});
    compare(cmd_o, c, {tag, " cmd"});
    compare(state_o, exp_s, {tag, " state"});
    pins(K_NOP);
    ap_flag = 1'b0; pall_flag = 1'b0; bank_hit = 1'b0;
  endtask

  // n more samples of a timed state: n-1 inside, the last one after exit.
  task automatic hold(input int n, input logic [3:0] during, input logic [3:0] after,
                      input string tag);
    for (int i = 1; i < n; i++) send(K_NOP, 0, 0, 0, 1, during, {tag, " window"});
    send(K_NOP, 0, 0, 0, 1, after, {tag, " exit"});
  endtask

  task automatic open_row();
    send(K_ACT, 0, 0, 1, 1, Q_OPEN, "R3 act");
    hold(3, Q_OPEN, Q_ROW, "R7 trcd");
  endtask

  task automatic t_reset();
    compare(state_o, Q_IDLE, "R1 reset state");
    compare({3'b0, legal_o}, 4'd1, "R1 reset legal");
    compare(cmd_o, K_DES, "R1 reset cmd");
  endtask

  task automatic t_decode();
    send(K_DES, 0, 0, 1, 1, Q_IDLE, "R1 R2 deselect");
    send(K_NOP, 0, 0, 1, 1, Q_IDLE, "R1 R2 nop");
    send(K_ACT, 0, 0, 0, 1, Q_IDLE, "R1 R11 act other bank");
    send(K_RD,  0, 0, 0, 1, Q_IDLE, "R1 R11 read other bank");
    send(K_WR,  0, 0, 0, 1, Q_IDLE, "R1 R11 write other bank");
    send(K_PRE, 0, 0, 0, 1, Q_IDLE, "R1 R11 pre other bank");
    send(K_BST, 0, 0, 0, 0, Q_IDLE, "R1 R9 bst no read");
    peers_idle = 1'b0;
    send(K_REF, 0, 0, 0, 0, Q_IDLE, "R1 R3 ref peers busy");
    send(K_MRS, 0, 0, 0, 0, Q_IDLE, "R1 R3 mrs peers busy");
    peers_idle = 1'b1;
  endtask

  task automatic t_idle();
    send(K_RD,  0, 0, 1, 0, Q_IDLE, "R3 R12 read in idle");
    send(K_PRE, 0, 0, 1, 0, Q_IDLE, "R3 R12 pre in idle");
    send(K_ACT, 0, 0, 1, 1, Q_OPEN, "R3 act");
    send(K_RD,  0, 0, 1, 0, Q_OPEN, "R7 read while opening");
    hold(2, Q_OPEN, Q_ROW, "R7 trcd");
  endtask

  task automatic t_bursts();
    send(K_ACT, 0, 0, 1, 0, Q_ROW, "R4 act in row open");
    send(K_RD,  0, 0, 1, 1, Q_RD,  "R4 read");
    send(K_ACT, 0, 0, 1, 0, Q_RD,  "R5 act in read");
    send(K_WR,  0, 0, 1, 1, Q_WR,  "R5 write after read");
    send(K_BST, 0, 0, 0, 0, Q_WR,  "R6 bst in write");
    send(K_ACT, 0, 0, 1, 0, Q_WR,  "R6 act in write");
    send(K_RD,  0, 0, 1, 1, Q_RD,  "R6 read after write");
    send(K_BST, 0, 0, 0, 1, Q_ROW, "R9 bst ends read");
    send(K_WR,  0, 0, 1, 1, Q_WR,  "R4 write");
    hold(4, Q_WR, Q_ROW, "R13 burst expiry");
    send(K_RD,  1, 0, 1, 1, Q_RDAP, "R4 read autopre");
    send(K_WR,  0, 0, 1, 0, Q_RDAP, "R7 write in rdap");
    send(K_BST, 0, 0, 0, 0, Q_RDAP, "R9 bst in rdap");
    hold(4, Q_RDAP, Q_IDLE, "R7 rdap window");
    open_row();
    send(K_WR,  1, 0, 1, 1, Q_WRAP, "R4 write autopre");
    hold(6, Q_WRAP, Q_IDLE, "R7 wrap window");
  endtask

  task automatic t_precharge();
    open_row();
    send(K_PRE, 0, 0, 1, 1, Q_PRE, "R4 precharge");
    hold(2, Q_PRE, Q_IDLE, "R7 trp");
    open_row();
    send(K_RD,  0, 0, 1, 1, Q_RD, "R5 read");
    send(K_PRE, 0, 0, 1, 1, Q_PRE, "R5 pre cuts read");
    hold(2, Q_PRE, Q_IDLE, "R7 trp after read");
  endtask

  task automatic t_device();
    send(K_REF, 0, 0, 0, 1, Q_REF, "R3 refresh");
    send(K_ACT, 0, 0, 0, 0, Q_REF, "R8 act other bank in refresh");
    send(K_BST, 0, 0, 0, 0, Q_REF, "R8 bst in refresh");
    hold(3, Q_REF, Q_IDLE, "R8 trfc");
    send(K_MRS, 0, 0, 0, 1, Q_MODE, "R3 mode set");
    send(K_PRE, 0, 1, 0, 0, Q_MODE, "R8 pre-all in mode");
    hold(1, Q_MODE, Q_IDLE, "R8 tmrd");
    send(K_PRE, 0, 1, 0, 1, Q_PALL, "R10 pre-all from idle");
    send(K_RD,  0, 0, 0, 0, Q_PALL, "R8 read other bank in pall");
    hold(1, Q_PALL, Q_IDLE, "R8 pall trp");
  endtask

  task automatic t_pall();
    open_row();
    send(K_WR,  0, 0, 1, 1, Q_WR, "R4 write");
    send(K_PRE, 0, 1, 0, 1, Q_PALL, "R10 pre-all from write");
    hold(2, Q_PALL, Q_IDLE, "R10 pall trp");
    send(K_ACT, 0, 0, 1, 1, Q_OPEN, "R3 act");
    send(K_PRE, 0, 1, 0, 0, Q_OPEN, "R10 pre-all while opening");
    hold(2, Q_OPEN, Q_ROW, "R7 trcd");
  endtask

  task automatic t_peer_and_other();
    peer_rd_recent = 1'b1;
    send(K_BST, 0, 0, 0, 1, Q_ROW, "R9 peer bst in row");
    send(K_WR,  0, 0, 1, 1, Q_WR,  "R4 write");
    send(K_BST, 0, 0, 1, 1, Q_WR,  "R9 peer bst keeps write");
    hold(3, Q_WR, Q_ROW, "R13 burst expiry");
    peer_rd_recent = 1'b0;
    send(K_ACT, 0, 0, 0, 1, Q_ROW, "R11 act other bank");
    send(K_PRE, 0, 0, 0, 1, Q_ROW, "R11 pre other bank");
    send(K_MRS, 0, 0, 0, 0, Q_ROW, "R12 mrs when not idle");
    send(K_DES, 0, 0, 0, 1, Q_ROW, "R2 deselect in row");
  endtask

  task automatic t_zero_window();
    cfg_trp = 8'd0;
    send(K_PRE, 0, 0, 1, 1, Q_PRE, "R13 zero trp");
    hold(1, Q_PRE, Q_IDLE, "R13 zero window one cycle");
    cfg_trp = 8'd2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_idle();
    t_bursts();
    t_precharge();
    t_device();
    t_pall();
    t_peer_and_other();
    t_zero_window();
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule